// File: doc/BRIEF.md
# Loop-Unrolled Decision Feedback Equalizer

This block turns a stream of signed, digitized receiver samples into one binary decision per bit-time. It cancels post-cursor intersymbol interference by subtracting weighted copies of earlier decisions from each sample before slicing it. Decision 1 stands for symbol +1 and decision 0 for symbol -1.

The first one or two feedback taps are resolved speculatively, so no adder sits in the one-bit-time loop. Every possible history of those taps gets its own comparator, and each comparator's threshold already carries that history's weight contribution. The registered results wait in parallel until the previous decisions are known. A multiplexer driven by those decisions then picks one result. The taps beyond the unrolled ones are summed from registered decisions and subtracted one cycle ahead.

Tap weights and the slicer threshold are static inputs, set while no samples are in flight.

Top module: `lu_dfe`

## Requirements
- R1: For each accepted sample x, dec_bit is 1 exactly when x minus the sum over n of w_n·s_n is greater than or equal to thresh. Here s_n is +1 if the n-th previous decision was 1 and -1 if it was 0. Tap n is the signed 8-bit field tap_w[(n-1)*8 +: 8], and thresh is signed.
- R2: A sample accepted at rising edge k (in_valid high) has its decision on dec_bit, with dec_valid high, during exactly the cycle that follows rising edge k+1.
- R3: While rst_n is low, and after it rises until the first decision, dec_valid is low. rst_n acts asynchronously when asserted, and its release takes effect on the second rising edge after it rises. Decisions after reset use a history of all -1 symbols.
- R4: A cycle with in_valid low is ignored: it produces no decision and leaves the decision history unchanged, whatever in_sample holds.
- R5: Any pattern of idle cycles between samples gives the same decisions as back-to-back samples.
- R6: With one unrolled tap (NUNROLL=1) or two (NUNROLL=2), the block gives bit-identical decisions.
- R7: Weights over the full range -128 to +127 on every tap, and any threshold, are handled without arithmetic overflow.
- R8: Exactly one decision is produced per accepted sample, in the order the samples arrive, and none otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bit-time per sample |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Qualifies in_sample this cycle |
| in_sample | input | SW | Signed received sample |
| thresh | input | SW | Signed nominal slicer threshold |
| tap_w | input | NTAPS*8 | Packed signed tap weights, tap 1 in the low byte |
| dec_valid | output | 1 | A decision is presented this cycle |
| dec_bit | output | 1 | Decision, 1 for +1 and 0 for -1 |

## Verification
The hardest situation to reach from the ports is a gap in the input. When a sample arrives while the previous one is still waiting in the candidate register, the non-unrolled taps must read the history one place lower than when the pipeline is empty. The slicing stays exact only if that shift is right. To reach it, the stimulus mixes back-to-back, alternate-cycle and randomly gapped runs through an interference channel whose post-cursors match the tap weights. These runs include rows at extreme weights, so that decisions flip often. Two instances, one per unroll mode, see the same stream. Each is compared bit for bit against a plain feedback equalizer computed in the bench.

// File: rtl/lu_dfe_pkg.sv
`timescale 1ns/1ps
package lu_dfe_pkg;
  localparam int WGT_W = 8;
  typedef logic signed [WGT_W-1:0] wgt_t;
  typedef logic signed [WGT_W:0]   term_t;

  // weight times symbol: +w for decision 1, -w for decision 0
  function automatic term_t signed_term(wgt_t w, logic b);
    term_t e;
    e = {w[WGT_W-1], w};
    return b ? e : -e;
  endfunction
endpackage

// File: rtl/lu_dfe_tail.sv
`timescale 1ns/1ps
module lu_dfe_tail import lu_dfe_pkg::*; #(
  parameter int NTAPS   = 4,
  parameter int NUNROLL = 2,
  parameter int AW      = 22
) (
  input  logic [NTAPS-NUNROLL:0]             hist_win,
  input  logic                               pend,
  input  logic [(NTAPS-NUNROLL)*WGT_W-1:0]   tail_w,
  output logic signed [AW-1:0]               tail
);
  localparam int NT = NTAPS - NUNROLL;

  term_t terms [NT];

  genvar t;
  generate
    for (t = 0; t < NT; t++) begin : g_term
      logic hb;
      // while a sample waits in the candidate stage, the newest history
      // entry is one older than the sample being entered
      assign hb = pend ? hist_win[t] : hist_win[t+1];
      assign terms[t] = signed_term(tail_w[t*WGT_W +: WGT_W], hb);
    end
  endgenerate

  always_comb begin
    tail = '0;
    for (int i = 0; i < NT; i++) begin
      tail = tail + {{(AW-WGT_W-1){terms[i][WGT_W]}}, terms[i]};
    end
  end
endmodule

// File: rtl/lu_dfe_slicer.sv
`timescale 1ns/1ps
module lu_dfe_slicer import lu_dfe_pkg::*; #(
  parameter int SW      = 10,
  parameter int NUNROLL = 2,
  parameter int AW      = 22
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic signed [SW-1:0]          in_sample,
  input  logic signed [SW-1:0]          thresh,
  input  logic [NUNROLL*WGT_W-1:0]      spec_w,
  input  logic signed [AW-1:0]          tail,
  output logic                          s1_vld,
  output logic [(1<<NUNROLL)-1:0]       s1_cand
);
  localparam int NC = 1 << NUNROLL;

  logic signed [AW-1:0] y_c;
  logic signed [AW-1:0] thr_h [NC];
  logic [NC-1:0]        cand_c;
  logic                 vld_d;
  logic [NC-1:0]        cand_d;

  always_comb begin
    term_t tm;
    y_c = {{(AW-SW){in_sample[SW-1]}}, in_sample} - tail;
    for (int h = 0; h < NC; h++) begin
      thr_h[h] = {{(AW-SW){thresh[SW-1]}}, thresh};
      for (int j = 0; j < NUNROLL; j++) begin
        tm = signed_term(spec_w[j*WGT_W +: WGT_W], h[j]);
        thr_h[h] = thr_h[h] + {{(AW-WGT_W-1){tm[WGT_W]}}, tm};
      end
      cand_c[h] = (y_c >= thr_h[h]);
    end
  end

  always_comb begin
    vld_d  = in_valid;
    cand_d = in_valid ? cand_c : s1_cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_cand <= '0;
    end else begin
      s1_vld  <= vld_d;
      s1_cand <= cand_d;
    end
  end

  genvar g, k;
  generate
    for (g = 0; g < NC; g++) begin : g_lo
      for (k = 0; k < NC; k++) begin : g_hi
        if (g != k) begin : g_pair
          // R1
          mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (thr_h[g] <= thr_h[k]) && cand_c[k]) |-> cand_c[g]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lu_dfe_select.sv
`timescale 1ns/1ps
module lu_dfe_select #(
  parameter int NTAPS   = 4,
  parameter int NUNROLL = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s1_vld,
  input  logic [(1<<NUNROLL)-1:0]     s1_cand,
  output logic                        dec_valid,
  output logic                        dec_bit,
  output logic [NTAPS-1:NUNROLL-1]    hist_tail
);
  logic [NTAPS-1:0]   hist_q;
  logic [NTAPS-1:0]   hist_d;
  logic               dv_q;
  logic               dv_d;
  logic [NUNROLL-1:0] sel;
  logic               pick;

  always_comb begin
    sel    = hist_q[NUNROLL-1:0];
    pick   = s1_cand[sel];
    hist_d = s1_vld ? {hist_q[NTAPS-2:0], pick} : hist_q;
    dv_d   = s1_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      dv_q   <= 1'b0;
    end else begin
      hist_q <= hist_d;
      dv_q   <= dv_d;
    end
  end

  assign dec_valid = dv_q;
  assign dec_bit   = hist_q[0];
  assign hist_tail = hist_q[NTAPS-1:NUNROLL-1];

  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(hist_q));
  // R8
  dec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> dec_valid);
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !dec_valid);
endmodule

// File: rtl/lu_dfe.sv
`timescale 1ns/1ps
module lu_dfe import lu_dfe_pkg::*; #(
  parameter int SW      = 10,
  parameter int NTAPS   = 4,
  parameter int NUNROLL = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SW-1:0]       in_sample,
  input  logic signed [SW-1:0]       thresh,
  input  logic [NTAPS*WGT_W-1:0]     tap_w,
  output logic                       dec_valid,
  output logic                       dec_bit
);
  localparam int AW = SW + WGT_W + $clog2(NTAPS + 1) + 1;
  localparam int NC = 1 << NUNROLL;

  logic [1:0] sync_q;
  logic [1:0] sync_d;
  logic       rst_sync_n;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end
  assign rst_sync_n = sync_q[1];

  logic signed [AW-1:0]       tail;
  logic                       s1_vld;
  logic [NC-1:0]              s1_cand;
  logic [NTAPS-1:NUNROLL-1]   hist_tail;

  generate
    if (NTAPS > NUNROLL) begin : g_tail
      lu_dfe_tail #(.NTAPS(NTAPS), .NUNROLL(NUNROLL), .AW(AW)) tail_i (
        .hist_win (hist_tail),
        .pend     (s1_vld),
        .tail_w   (tap_w[NTAPS*WGT_W-1:NUNROLL*WGT_W]),
        .tail     (tail)
      );
    end else begin : g_notail
      assign tail = '0;
    end
  endgenerate

  lu_dfe_slicer #(.SW(SW), .NUNROLL(NUNROLL), .AW(AW)) slicer_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .thresh    (thresh),
    .spec_w    (tap_w[NUNROLL*WGT_W-1:0]),
    .tail      (tail),
    .s1_vld    (s1_vld),
    .s1_cand   (s1_cand)
  );

  lu_dfe_select #(.NTAPS(NTAPS), .NUNROLL(NUNROLL)) select_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .s1_vld    (s1_vld),
    .s1_cand   (s1_cand),
    .dec_valid (dec_valid),
    .dec_bit   (dec_bit),
    .hist_tail (hist_tail)
  );

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> ##1 dec_valid);
endmodule

// File: tb/lu_dfe_tb_top.sv
`timescale 1ns/1ps
module lu_dfe_tb_top;
  localparam int SW  = 10;
  localparam int NT  = 4;
  localparam int NSC = 6;
  localparam int NS  = 300;

  localparam logic signed [7:0] WT [NSC][NT] = '{
    '{8'sd40,  8'sd20,  8'sd10,  8'sd5},
    '{-8'sd60, 8'sd30,  -8'sd15, 8'sd8},
    '{8'sd127, 8'h80,   8'sd60,  -8'sd60},
    '{8'sd0,   8'sd0,   8'sd0,   8'sd0},
    '{8'sd25,  -8'sd25, 8'sd90,  -8'sd90},
    '{8'h80,   8'h80,   8'h80,   8'h80}
  };
  localparam logic signed [SW-1:0] TH [NSC] = '{
    10'sd0, 10'sd0, 10'sd10, 10'sd0, -10'sd20, 10'sd0 };
  localparam int GP [NSC] = '{0, 1, 2, 0, 2, 0};

  logic clk;
  logic rst_n;
  logic in_valid;
  logic signed [SW-1:0] in_sample;
  logic signed [SW-1:0] thresh;
  logic [NT*8-1:0] tap_w;
  logic dv2, db2, dv1, db1;

  lu_dfe #(.SW(SW), .NTAPS(NT), .NUNROLL(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .thresh(thresh), .tap_w(tap_w), .dec_valid(dv2), .dec_bit(db2));

  lu_dfe #(.SW(SW), .NTAPS(NT), .NUNROLL(1)) dut_u1_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .thresh(thresh), .tap_w(tap_w), .dec_valid(dv1), .dec_bit(db1));

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit q2[$];
  bit q1[$];
  logic [NT:1] rh;
  logic [NT:1] tx;
  int cw [1:NT];
  int cthr;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sym(input logic b);
    return b ? 1 : -1;
  endfunction

  function automatic logic ref_dec(input int x);
    int acc;
    acc = x;
    for (int j = 1; j <= NT; j++) acc = acc - cw[j] * sym(rh[j]);
    return (acc >= cthr);
  endfunction

  // output comparison against the reference queue
  always @(negedge clk) begin
    if (dv2) begin
      if (q2.size() == 0) check("R8", 1'b1, 1'b0);
      else check(cur_req, db2, q2.pop_front());
    end
    if (dv1) begin
      if (q1.size() == 0) check("R8", 1'b1, 1'b0);
      else check("R6", db1, q1.pop_front());
    end
  end

  task automatic send(input int x);
    logic d;
    @(posedge clk); #5;
    in_valid  = 1'b1;
    in_sample = x[SW-1:0];
    d = ref_dec(x);
    q2.push_back(d);
    q1.push_back(d);
    rh = {rh[NT-1:1], d};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      in_valid  = 1'b0;
      in_sample = SW'($urandom);
    end
  endtask

  task automatic set_cfg(input int sc);
    for (int j = 1; j <= NT; j++) begin
      cw[j] = int'(WT[sc][j-1]);
      tap_w[(j-1)*8 +: 8] = WT[sc][j-1];
    end
    cthr   = int'(TH[sc]);
    thresh = TH[sc];
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n    = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check("R3", dv2, 1'b0);
      check("R3", dv1, 1'b0);
    end
    @(posedge clk); #5;
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R3", dv2, 1'b0);
    end
    rh = '0;
    tx = '0;
  endtask

  function automatic int chan_sample(input logic b);
    int x;
    x = 100 * sym(b) + int'($urandom_range(30)) - 15;
    for (int j = 1; j <= NT; j++) x = x + cw[j] * sym(tx[j]);
    if (x > 511) x = 511;
    if (x < -512) x = -512;
    return x;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8: actual hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; thresh = '0; tap_w = '0;
    rh = '0; tx = '0;

    // scenario table walk
    for (int sc = 0; sc < NSC; sc++) begin
      set_cfg(sc);
      cur_req = (sc == 2 || sc == 5) ? "R7" : (GP[sc] != 0 ? "R5" : "R1");
      do_reset();
      for (int k = 0; k < NS; k++) begin
        logic b;
        b = 1'($urandom);
        send(chan_sample(b));
        tx = {tx[NT-1:1], b};
        if (GP[sc] == 1) idle(1);
        else if (GP[sc] == 2) idle(int'($urandom_range(2)));
      end
      idle(4);
      check_int("R8", q2.size(), 0);
      check_int("R8", q1.size(), 0);
    end

    // directed: latency and first-tap history after reset
    cur_req = "R3";
    for (int j = 1; j <= NT; j++) begin
      cw[j] = 0;
      tap_w[(j-1)*8 +: 8] = 8'sd0;
    end
    cw[1] = 100;
    tap_w[7:0] = 8'sd100;
    cthr = 0;
    thresh = '0;
    do_reset();
    send(50);          // history -1 after reset gives decision 1
    idle(1);           // this edge captures the sample
    @(negedge clk);
    check("R2", dv2, 1'b0);
    check("R2", dv1, 1'b0);
    @(negedge clk);
    check("R2", dv2, 1'b1);
    check("R3", db2, 1'b1);
    @(negedge clk);
    check("R2", dv2, 1'b0);

    // back-to-back alternation through the speculative tap
    cur_req = "R1";
    send(50);
    send(50);
    send(50);
    idle(4);

    // ignored cycles with junk samples
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #5;
      in_valid  = 1'b0;
      in_sample = (i % 2 == 0) ? 10'sd511 : -10'sd512;
      @(negedge clk);
      check("R4", dv2, 1'b0);
      check("R4", dv1, 1'b0);
    end
    cur_req = "R4";
    send(50);          // must follow the history left before the idle run
    idle(4);
    check_int("R8", q2.size(), 0);
    check_int("R8", q1.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule